// File: doc/BRIEF.md
# Strap Latch and PLL Mode Selector

This block sits between the chip-level control pins and the clock core. When the power-good input goes high for the first time it captures a three-level mode strap. The strap picks low-bandwidth PLL, bypass or high-bandwidth PLL. Later high and low levels on the same input only take the core into and out of power-down.

Two software fields can replace the captured values, each only while its enable bit is set. One field picks the PLL mode. The other picks the reference frequency, and that choice is held in a register inside the block. When the core enters power-down, a keep/clear bit decides what happens to that configuration. If it is cleared, a one-cycle strobe goes out and the stored frequency choice returns to its default.

A counter runs while power-good is high and raises a stable flag once the start-up wait has elapsed. The counter starts again from zero on every exit from power-down.

Top module: `strap_mode_ctrl`

## Requirements
- R1: On the first clock edge at which `pwrgd` is sampled high after reset, the strap decode is captured and mapped to a mode code. Strap `00` (low) gives mode `00` (low-bandwidth PLL). Strap `01` (mid) gives mode `01` (bypass). Strap `10` (high) gives mode `11` (high-bandwidth PLL). The undefined strap code `11` is treated as mid and gives `01`.
- R2: After the first capture, later falls and rises of `pwrgd` do not capture the strap again. The captured mode holds until reset.
- R3: `mode_rb` shows the captured mode from the cycle after capture. It reads `00` until the first capture.
- R4: While `sw_mode_en` is 1, `pll_mode` equals `sw_mode`. While it is 0, `pll_mode` equals the captured mode and `sw_mode` has no effect.
- R5: While `sw_freq_en` is 1, a `sw_freq` code of `00` (100 MHz), `01` (50 MHz) or `10` (125 MHz) is stored at a clock edge and appears on `freq_sel` after that edge. While `sw_freq_en` is 0, `freq_sel` reads `00`, although the stored choice is kept.
- R6: The reserved frequency code `11` is ignored and the stored choice is kept. `freq_sel` never reads `11`.
- R7: Power-down entry is a fall of `pwrgd` after the first capture. If `keep_cfg` is 0 at that fall, `cfg_clear` is high for exactly one cycle, starting at the edge after the fall. On the same edge that ends the strobe, the stored frequency choice returns to `00`. If `keep_cfg` is 1, no strobe is issued and the stored choice is kept.
- R8: `stable` rises after `STAB_CYCLES` consecutive clock edges with `pwrgd` high. It falls at the first edge with `pwrgd` low. The count restarts from zero on every exit from power-down.
- R9: After reset, `pll_mode`, `mode_rb`, `freq_sel`, `cfg_clear` and `stable` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_lvl | input | 2 | Three-level strap decode: 00 low, 01 mid, 10 high |
| pwrgd | input | 1 | Power-good; 0 means power-down |
| sw_mode_en | input | 1 | Enables the software mode field |
| sw_mode | input | 2 | Software PLL mode code |
| sw_freq_en | input | 1 | Enables the software frequency field |
| sw_freq | input | 2 | Software frequency code |
| keep_cfg | input | 1 | 1 keeps the configuration across power-down, 0 clears it |
| pll_mode | output | 2 | Resolved PLL mode |
| mode_rb | output | 2 | Captured strap mode (readback) |
| freq_sel | output | 2 | Resolved frequency select |
| cfg_clear | output | 1 | One-cycle configuration-clear strobe |
| stable | output | 1 | Start-up wait complete |

## Verification
The assertions assume that `pwrgd` and the register fields are synchronous to `clk`. They also assume these inputs change only between clock edges, and that the strap decode is valid at the first power-good edge. The stimulus meets these assumptions by driving every input at the falling clock edge. It sets the strap before raising `pwrgd` and holds `keep_cfg` steady across each power-down entry. The reserved frequency code is applied on purpose, so that the check that it is ignored is actually exercised.

// File: rtl/strap_mode_pkg.sv
package strap_mode_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_BAD  = 2'b11
    } strap_lvl_e;

    typedef enum logic [1:0] {
        MODE_LOBW = 2'b00,
        MODE_BYP  = 2'b01,
        MODE_HIBW = 2'b11
    } pll_mode_e;

    localparam logic [1:0] FREQ_100  = 2'b00;
    localparam logic [1:0] FREQ_RSVD = 2'b11;

    function automatic logic [1:0] strap_to_mode(input logic [1:0] lvl);
        case (lvl)
            LVL_LOW:  strap_to_mode = MODE_LOBW;
            LVL_HIGH: strap_to_mode = MODE_HIBW;
            default:  strap_to_mode = MODE_BYP;
        endcase
    endfunction

endpackage

// File: rtl/pd_sequencer.sv
module pd_sequencer #(
    parameter int STAB_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwrgd_i,
    input  logic keep_cfg_i,
    output logic first_rise_o,
    output logic cfg_clear_o,
    output logic stable_o
);
    localparam int CW = $clog2(STAB_CYCLES + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(STAB_CYCLES);

    typedef struct packed {
        logic          pg;
        logic          started;
        logic          clr;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic pd_entry;

    always_comb begin
        first_rise_o = pwrgd_i && !s_q.pg && !s_q.started;
        pd_entry     = !pwrgd_i && s_q.pg && s_q.started;
        s_d          = s_q;
        s_d.pg       = pwrgd_i;
        if (first_rise_o) s_d.started = 1'b1;
        s_d.clr      = pd_entry && !keep_cfg_i;
        if (!pwrgd_i)
            s_d.cnt = '0;
        else if (s_q.cnt != CNT_MAX)
            s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_clear_o = s_q.clr;
    assign stable_o    = (s_q.cnt == CNT_MAX);

    assert_clear_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clear_o |=> !cfg_clear_o);
    assert_clear_needs_keep_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clear_o |-> ($past(!keep_cfg_i) && $past(!pwrgd_i)));
    assert_stable_needs_pwrgd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stable_o |-> $past(pwrgd_i));
    assert_single_first_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        first_rise_o |=> !first_rise_o);

endmodule

// File: rtl/mode_latch.sv
module mode_latch
    import strap_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture_i,
    input  logic [1:0] strap_i,
    input  logic       sw_en_i,
    input  logic [1:0] sw_mode_i,
    output logic [1:0] mode_o,
    output logic [1:0] rb_o
);
    typedef struct packed {
        logic       done;
        logic [1:0] mode;
    } lat_t;

    lat_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (capture_i && !l_q.done) begin
            l_d.done = 1'b1;
            l_d.mode = strap_to_mode(strap_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign rb_o   = l_q.mode;
    assign mode_o = sw_en_i ? sw_mode_i : l_q.mode;

    assert_rb_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        l_q.done |=> $stable(rb_o));
    assert_rb_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rb_o != 2'b10);
    assert_sw_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_en_i && $past(!sw_en_i) && $stable(rb_o)) |-> $stable(mode_o));

endmodule

// File: rtl/freq_select.sv
module freq_select
    import strap_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [1:0] code_i,
    input  logic       clear_i,
    output logic [1:0] freq_o
);
    typedef struct packed {
        logic [1:0] sel;
    } frq_t;

    frq_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (clear_i)
            f_d.sel = FREQ_100;
        else if (en_i && code_i != FREQ_RSVD)
            f_d.sel = code_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign freq_o = en_i ? f_q.sel : FREQ_100;

    assert_rsvd_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && code_i == FREQ_RSVD && !clear_i) |=> $stable(f_q.sel));
    assert_never_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        freq_o != FREQ_RSVD);
    assert_clear_defaults_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (f_q.sel == FREQ_100));

endmodule

// File: rtl/strap_mode_ctrl.sv
module strap_mode_ctrl #(
    parameter int STAB_CYCLES = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap_lvl,
    input  logic       pwrgd,
    input  logic       sw_mode_en,
    input  logic [1:0] sw_mode,
    input  logic       sw_freq_en,
    input  logic [1:0] sw_freq,
    input  logic       keep_cfg,
    output logic [1:0] pll_mode,
    output logic [1:0] mode_rb,
    output logic [1:0] freq_sel,
    output logic       cfg_clear,
    output logic       stable
);
    logic first_rise;

    pd_sequencer #(.STAB_CYCLES(STAB_CYCLES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwrgd_i     (pwrgd),
        .keep_cfg_i  (keep_cfg),
        .first_rise_o(first_rise),
        .cfg_clear_o (cfg_clear),
        .stable_o    (stable)
    );

    mode_latch u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture_i(first_rise),
        .strap_i  (strap_lvl),
        .sw_en_i  (sw_mode_en),
        .sw_mode_i(sw_mode),
        .mode_o   (pll_mode),
        .rb_o     (mode_rb)
    );

    freq_select u_freq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (sw_freq_en),
        .code_i (sw_freq),
        .clear_i(cfg_clear),
        .freq_o (freq_sel)
    );

endmodule

// File: tb/strap_mode_ctrl_tb.sv
module strap_mode_ctrl_tb;
    localparam int STAB = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] strap_lvl = 2'b00;
    logic       pwrgd = 1'b0;
    logic       sw_mode_en = 1'b0;
    logic [1:0] sw_mode = 2'b00;
    logic       sw_freq_en = 1'b0;
    logic [1:0] sw_freq = 2'b00;
    logic       keep_cfg = 1'b1;
    logic [1:0] pll_mode, mode_rb, freq_sel;
    logic       cfg_clear, stable;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    strap_mode_ctrl #(.STAB_CYCLES(STAB)) u_dut (
        .clk(clk), .rst_n(rst_n), .strap_lvl(strap_lvl), .pwrgd(pwrgd),
        .sw_mode_en(sw_mode_en), .sw_mode(sw_mode), .sw_freq_en(sw_freq_en),
        .sw_freq(sw_freq), .keep_cfg(keep_cfg), .pll_mode(pll_mode),
        .mode_rb(mode_rb), .freq_sel(freq_sel), .cfg_clear(cfg_clear),
        .stable(stable)
    );

    // [9] mode_en [8:7] mode [6] freq_en [5:4] freq [3:2] exp mode [1:0] exp freq
    localparam logic [9:0] VEC [6] = '{
        10'b0_01_0_01_11_00,
        10'b1_01_1_01_01_01,
        10'b1_00_1_11_00_01,
        10'b0_00_1_10_11_10,
        10'b1_11_0_10_11_00,
        10'b1_01_1_11_01_10
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0; pwrgd = 1'b0; sw_mode_en = 1'b0; sw_freq_en = 1'b0;
        sw_mode = 2'b00; sw_freq = 2'b00; keep_cfg = 1'b1;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic power_up_with(input logic [1:0] lvl);
        strap_lvl = lvl;
        cyc(1);
        pwrgd = 1'b1;
        cyc(1);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [1:0] expm [4];
        expm[0] = 2'b00; expm[1] = 2'b01; expm[2] = 2'b11; expm[3] = 2'b01;

        do_reset();
        // R9 reset state
        chk("R9 pll_mode", int'(pll_mode), 0);
        chk("R9 mode_rb", int'(mode_rb), 0);
        chk("R9 freq_sel", int'(freq_sel), 0);
        chk("R9 cfg_clear", int'(cfg_clear), 0);
        chk("R9 stable", int'(stable), 0);
        strap_lvl = 2'b10;
        cyc(2);
        chk("R3 rb before capture", int'(mode_rb), 0);

        // R1 strap decode, each level
        for (int i = 0; i < 4; i++) begin
            do_reset();
            power_up_with(2'(i));
            chk("R1 strap decode", int'(mode_rb), int'(expm[i]));
            chk("R3 pll_mode follows capture", int'(pll_mode), int'(expm[i]));
        end

        // strap high captured, walk the vector table (R4 R5 R6)
        do_reset();
        power_up_with(2'b10);
        for (int v = 0; v < 6; v++) begin
            sw_mode_en = VEC[v][9];
            sw_mode    = VEC[v][8:7];
            sw_freq_en = VEC[v][6];
            sw_freq    = VEC[v][5:4];
            cyc(1);
            chk("R4 mode vector", int'(pll_mode), int'(VEC[v][3:2]));
            chk("R5 R6 freq vector", int'(freq_sel), int'(VEC[v][1:0]));
        end

        // R2: power cycle with different strap, no recapture
        sw_mode_en = 1'b0;
        strap_lvl = 2'b00;
        keep_cfg = 1'b1;
        pwrgd = 1'b0;
        cyc(3);
        pwrgd = 1'b1;
        cyc(2);
        chk("R2 no recapture", int'(mode_rb), 3);
        chk("R7 keep no strobe", int'(cfg_clear), 0);
        // stored freq still 10 with keep_cfg=1, sw_freq still 11
        chk("R7 keep retains freq", int'(freq_sel), 2);

        // R8 stable timing after this exit: pwrgd high for 2 edges so far
        cyc(STAB - 3);
        chk("R8 stable not yet", int'(stable), 0);
        cyc(1);
        chk("R8 stable asserted", int'(stable), 1);

        // R7 clear path
        keep_cfg = 1'b0;
        pwrgd = 1'b0;
        cyc(1);
        chk("R7 strobe high", int'(cfg_clear), 1);
        chk("R8 stable drops", int'(stable), 0);
        cyc(1);
        chk("R7 strobe one cycle", int'(cfg_clear), 0);
        chk("R7 freq cleared", int'(freq_sel), 0);
        cyc(3);
        chk("R7 no second strobe", int'(cfg_clear), 0);

        // R8 restart after exit
        keep_cfg = 1'b1;
        pwrgd = 1'b1;
        cyc(STAB - 1);
        chk("R8 restart not yet", int'(stable), 0);
        cyc(1);
        chk("R8 restart asserted", int'(stable), 1);
        chk("R2 rb held after cycles", int'(mode_rb), 3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule